// File: doc/BRIEF.md
# Tracking Signal-Strength Converter with Squelch Gate

This block keeps a 6-bit signal-strength code and moves it toward the measured analog level one step per conversion tick. An external comparator tells it whether the selected analog input lies above the level that the current code produces on an external DAC. On each tick the code moves one LSB up or down and stops at the ends of the range, so a swing across the full scale takes 63 ticks. Between ticks the code does not change.

The code drives a squelch gate. The gate passes the demodulated data bit only while the code is above a programmable threshold. An optional hysteresis band of two LSBs on each side of the threshold stops the gate from chattering near the limit. The converter can measure one of several analog sources: the received-signal-strength path, the supply voltage or the discriminator DC level. A change of source sets the code back to mid-scale and lowers the valid flag until a full-range settling interval has passed. The comparator and the DAC are analog parts outside the block.

Top module: `rssi_track_squelch`

## Requirements
- R1: During reset and right after it, `level_code` is 32, `level_valid` is 0, `sq_open` is 0 and `data_out` is 0.
- R2: On a clock edge with `conv_tick` high and no source change, `level_code` rises by one if `cmp_above` is 1 and falls by one if it is 0. Without `conv_tick` the code holds.
- R3: The code saturates. An up step at 63 leaves 63 and a down step at 0 leaves 0.
- R4: With `hyst_en` at 0, `sq_open` becomes, one cycle later, the result of `level_code > sq_thresh` (unsigned).
- R5: With `hyst_en` at 1, a closed gate opens only when the code exceeds `sq_thresh`+2, and an open gate closes only when the code+2 is below `sq_thresh`. The sums are computed 7 bits wide, so a threshold above 60 never opens the gate and one below 2 never closes it.
- R6: `data_out` equals `data_in` while both `sq_open` and `level_valid` are 1. Otherwise it is 0, with no added delay.
- R7: `meas_src` is encoded as 0 for signal strength, 1 for supply and 2 for discriminator DC (3 is reserved). Any change of its value since the last clock edge sets the code to 32 and `level_valid` to 0 on the next edge, whatever the tick is.
- R8: `level_valid` rises once 63 ticks have been counted since reset or the last source change. It then stays high until the next source change.
- R9: From code 0, with the comparator held at 1, the code reads 62 after 62 ticks and 63 after 63 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_tick | input | 1 | One-cycle conversion enable (one per conversion period) |
| cmp_above | input | 1 | Comparator: analog input above DAC level of current code |
| meas_src | input | 2 | Selected analog source for the converter |
| sq_thresh | input | 6 | Squelch threshold code |
| hyst_en | input | 1 | Enables the ±2 LSB hysteresis band |
| data_in | input | 1 | Demodulated data bit |
| level_code | output | 6 | Current tracked code, also drives the external DAC |
| level_valid | output | 1 | Code has settled since reset or the last source change |
| sq_open | output | 1 | Squelch gate state (signal present) |
| data_out | output | 1 | Gated data bit |

## Verification
The assertions take `conv_tick` and `cmp_above` as synchronous inputs that are stable around the clock edge. They also assume that `meas_src` changes only between edges, so that a change is seen at exactly one edge. The bench drives every input on the falling edge. It derives the comparator from a modelled analog level against the current code, as an ideal DAC and comparator would. It changes the source only now and then, so that the settling interval can finish between changes. Random thresholds and levels include values next to 0, 63 and the hysteresis edges.

// File: rtl/rssi_trk_pkg.sv
package rssi_trk_pkg;
    localparam int CODE_W = 6;
    localparam int SRC_W  = 2;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [SRC_W-1:0]  src_t;

    typedef struct packed {
        code_t code;
        src_t  src;
    } trk_state_t;

    typedef enum logic [SRC_W-1:0] {
        SRC_SIGNAL = 2'd0,
        SRC_SUPPLY = 2'd1,
        SRC_DISC   = 2'd2,
        SRC_RSVD   = 2'd3
    } src_e;
endpackage

// File: rtl/rssi_step_tracker.sv
module rssi_step_tracker #(
    parameter int W  = 6,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          above,
    input  logic [SW-1:0] src_sel,
    output logic [W-1:0]  code,
    output logic          src_chg
);
    localparam logic [W-1:0] CODE_MAX = {W{1'b1}};
    localparam logic [W-1:0] CODE_MID = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        logic [W-1:0]  code;
        logic [SW-1:0] src;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        src_chg = (src_sel != st_q.src);
        st_d.src = src_sel;
        if (src_chg) begin
            st_d.code = CODE_MID;
        end else if (tick) begin
            if (above) begin
                if (st_q.code != CODE_MAX) st_d.code = st_q.code + 1'b1;
            end else begin
                if (st_q.code != '0) st_d.code = st_q.code - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.code <= CODE_MID;
            st_q.src  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code = st_q.code;
endmodule

// File: rtl/rssi_settle_timer.sv
module rssi_settle_timer #(
    parameter int LIMIT = 63
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    output logic settled
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)                 cnt_d = '0;
        else if (tick && cnt_q != LIM) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign settled = (cnt_q == LIM);
endmodule

// File: rtl/rssi_squelch_gate.sv
module rssi_squelch_gate #(
    parameter int W    = 6,
    parameter int HYST = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] code,
    input  logic [W-1:0] thresh,
    input  logic         hyst_en,
    output logic         open
);
    localparam logic [W:0] HB = (W+1)'(HYST);

    logic open_d, open_q;
    logic [W:0] code_x, thr_x;

    always_comb begin
        code_x = {1'b0, code};
        thr_x  = {1'b0, thresh};
        if (!hyst_en) begin
            open_d = (code_x > thr_x);
        end else if (open_q) begin
            open_d = !((code_x + HB) < thr_x);
        end else begin
            open_d = (code_x > (thr_x + HB));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) open_q <= 1'b0;
        else        open_q <= open_d;
    end

    assign open = open_q;
endmodule

// File: rtl/rssi_track_squelch.sv
module rssi_track_squelch
    import rssi_trk_pkg::*;
#(
    parameter int W    = CODE_W,
    parameter int SW   = SRC_W,
    parameter int HYST = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          conv_tick,
    input  logic          cmp_above,
    input  logic [SW-1:0] meas_src,
    input  logic [W-1:0]  sq_thresh,
    input  logic          hyst_en,
    input  logic          data_in,
    output logic [W-1:0]  level_code,
    output logic          level_valid,
    output logic          sq_open,
    output logic          data_out
);
    localparam int SETTLE = (1 << W) - 1;

    logic src_chg;

    rssi_step_tracker #(.W(W), .SW(SW)) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (conv_tick),
        .above   (cmp_above),
        .src_sel (meas_src),
        .code    (level_code),
        .src_chg (src_chg)
    );

    rssi_settle_timer #(.LIMIT(SETTLE)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (conv_tick),
        .restart (src_chg),
        .settled (level_valid)
    );

    rssi_squelch_gate #(.W(W), .HYST(HYST)) u_sq (
        .clk     (clk),
        .rst_n   (rst_n),
        .code    (level_code),
        .thresh  (sq_thresh),
        .hyst_en (hyst_en),
        .open    (sq_open)
    );

    assign data_out = data_in & sq_open & level_valid;
endmodule

// File: rtl/rssi_track_squelch_chk.sv
module rssi_track_squelch_chk #(
    parameter int W    = 6,
    parameter int HYST = 2
) (
    input logic         clk,
    input logic         rst_n,
    input logic         conv_tick,
    input logic         cmp_above,
    input logic [W-1:0] sq_thresh,
    input logic         hyst_en,
    input logic [W-1:0] level_code,
    input logic         level_valid,
    input logic         sq_open,
    input logic         data_out,
    input logic         src_chg
);
    localparam logic [W-1:0] CMAX = {W{1'b1}};
    localparam logic [W-1:0] CMID = {1'b1, {(W-1){1'b0}}};
    localparam logic [W:0]   HB   = (W+1)'(HYST);

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_tick && !src_chg) |=> $stable(level_code));

    assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_tick && !src_chg && cmp_above && level_code != CMAX)
        |=> level_code == $past(level_code) + 1'b1);

    assert_sat_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_tick && !src_chg && cmp_above && level_code == CMAX)
        |=> level_code == CMAX);

    assert_sat_bot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_tick && !src_chg && !cmp_above && level_code == '0)
        |=> level_code == '0);

    assert_hyst_stay_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hyst_en && !sq_open && ({1'b0, level_code} <= {1'b0, sq_thresh} + HB))
        |=> !sq_open);

    assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sq_open && level_valid) |-> !data_out);

    assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        src_chg |=> (level_code == CMID && !level_valid));
endmodule

bind rssi_track_squelch rssi_track_squelch_chk #(.W(W), .HYST(HYST)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_tick   (conv_tick),
    .cmp_above   (cmp_above),
    .sq_thresh   (sq_thresh),
    .hyst_en     (hyst_en),
    .level_code  (level_code),
    .level_valid (level_valid),
    .sq_open     (sq_open),
    .data_out    (data_out),
    .src_chg     (src_chg)
);

// File: tb/rssi_track_squelch_test.sv
module rssi_track_squelch_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       conv_tick;
    logic       cmp_above;
    logic [1:0] meas_src;
    logic [5:0] sq_thresh;
    logic       hyst_en;
    logic       data_in;
    logic [5:0] level_code;
    logic       level_valid;
    logic       sq_open;
    logic       data_out;

    int ain;
    int checks = 0;
    int fails  = 0;
    int m_code, m_cnt, m_open, m_src;
    string open_tag = "R4";

    always #2.5 clk = ~clk;

    assign cmp_above = (ain > int'(level_code));

    rssi_track_squelch uut (
        .clk(clk), .rst_n(rst_n), .conv_tick(conv_tick), .cmp_above(cmp_above),
        .meas_src(meas_src), .sq_thresh(sq_thresh), .hyst_en(hyst_en),
        .data_in(data_in), .level_code(level_code), .level_valid(level_valid),
        .sq_open(sq_open), .data_out(data_out)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int exp_open(int code, int thr, int hy, int op);
        if (hy == 0) return (code > thr) ? 1 : 0;
        if (op != 0) return ((code + 2) < thr) ? 0 : 1;
        return (code > thr + 2) ? 1 : 0;
    endfunction

    // one clock: outputs checked before the edge, model advanced after it
    task automatic cycle();
        int cmp, chg;
        #1;
        check("R2", "code", int'(level_code), m_code);
        check("R8", "valid", int'(level_valid), (m_cnt == 63) ? 1 : 0);
        check(open_tag, "open", int'(sq_open), m_open);
        check("R6", "data_out", int'(data_out), int'(data_in) & m_open & ((m_cnt == 63) ? 1 : 0));
        @(posedge clk);
        cmp = (ain > m_code) ? 1 : 0;
        chg = (int'(meas_src) != m_src) ? 1 : 0;
        m_open = exp_open(m_code, int'(sq_thresh), int'(hyst_en), m_open);
        open_tag = hyst_en ? "R5" : "R4";
        if (chg != 0) begin
            m_code = 32; m_cnt = 0;
        end else if (conv_tick) begin
            if (cmp != 0) m_code = (m_code < 63) ? m_code + 1 : 63;
            else          m_code = (m_code > 0) ? m_code - 1 : 0;
            if (m_cnt < 63) m_cnt++;
        end
        m_src = int'(meas_src);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h0000_5eed));
        rst_n = 1'b0; conv_tick = 0; meas_src = 0; sq_thresh = 6'd20;
        hyst_en = 0; data_in = 1; ain = 0;
        m_code = 32; m_cnt = 0; m_open = 0; m_src = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "code in reset", int'(level_code), 32);
        check("R1", "valid in reset", int'(level_valid), 0);
        check("R1", "open in reset", int'(sq_open), 0);
        check("R1", "data_out in reset", int'(data_out), 0);
        rst_n = 1'b1;
        cycle();

        // R3 floor and R9 full swing
        ain = -5; conv_tick = 1;
        for (int i = 0; i < 40; i++) cycle();
        check("R3", "floor", int'(level_code), 0);
        ain = 100;
        for (int i = 0; i < 62; i++) cycle();
        #1 check("R9", "after 62 ticks", int'(level_code), 62);
        cycle();
        #1 check("R9", "after 63 ticks", int'(level_code), 63);
        for (int i = 0; i < 5; i++) cycle();
        check("R3", "ceiling", int'(level_code), 63);
        check("R8", "valid after settling", int'(level_valid), 1);

        // R2: no tick holds
        conv_tick = 0; ain = 0;
        for (int i = 0; i < 10; i++) cycle();
        check("R2", "hold without tick", int'(level_code), 63);

        // R5 hysteresis sweep around threshold 30
        sq_thresh = 6'd30; hyst_en = 1; conv_tick = 1; ain = 20;
        for (int i = 0; i < 50; i++) cycle();
        ain = 40;
        for (int i = 0; i < 30; i++) cycle();
        ain = 20;
        for (int i = 0; i < 30; i++) cycle();
        // R5 threshold edges 0 and 63
        sq_thresh = 6'd63; ain = 100;
        for (int i = 0; i < 30; i++) cycle();
        check("R5", "thr 63 never opens", int'(sq_open), 0);
        sq_thresh = 6'd1; ain = -1;
        for (int i = 0; i < 70; i++) cycle();
        check("R5", "thr 1 never closes", int'(sq_open), 1);

        // R7 source change
        meas_src = 2'd1;
        cycle();
        #1 check("R7", "code after source change", int'(level_code), 32);
        check("R7", "valid after source change", int'(level_valid), 0);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            conv_tick = ($urandom_range(0, 1) == 1);
            data_in   = ($urandom_range(0, 1) == 1);
            if ($urandom_range(0, 99) == 0) sq_thresh = 6'($urandom_range(0, 63));
            if ($urandom_range(0, 149) == 0) hyst_en = ~hyst_en;
            if ($urandom_range(0, 49) == 0) ain = $urandom_range(0, 70) - 3;
            if ($urandom_range(0, 399) == 0) meas_src = 2'($urandom_range(0, 2));
            cycle();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule